// File: doc/BRIEF.md
# Bidirectional Dual-Clock Data Buffer

This block sits between a system interconnect running on a system clock and a processor cache-data bus running on a faster bus clock, the two clocks being locked at a 2:3 ratio. It holds words moving in both directions in two small dual-clock queues. Each queue crosses the clock boundary by passing Gray-coded pointers through two-flop synchronisers.

Fill direction (interconnect to processor): one reply strobe on the system side starts a fixed-length burst. The interconnect data bus is captured on the system-clock edges that follow. The processor then pulls the words out one at a time with a read strobe, and each word appears after a fixed two-cycle pipeline.

Post direction (processor to interconnect): the processor pushes one word per write strobe, with the data presented in the same cycle. A single system-side drain reply later streams a burst of stored words onto the interconnect output, also after a fixed two-cycle delay.

A request that finds its queue empty or full is dropped and raises a sticky error flag.

Top module: `xclk_data_buffer`

## Requirements
- R1: After a synchronous active-low reset of both domains, `sys_dout_vld` and `bus_dout_vld` are low, `sys_dout` and `bus_dout` are zero, and all four error flags are low.
- R2: When `sys_fill_rply` is sampled high on system edge k, `sys_din` is captured into the fill queue on each of the system edges k+1 through k+BURST_LEN.
- R3: When `bus_rd_req` is sampled high on bus edge k and the fill queue holds a word, that word is driven on `bus_dout` from bus edge k+2, and `bus_dout_vld` is high for exactly that one bus cycle.
- R4: In both directions, words leave the block in the order in which they entered it.
- R5: On every bus edge where `bus_wr_req` is high, the `bus_din` value of that same cycle is stored as one word of the post queue.
- R6: When `sys_drain_rply` is sampled high on system edge k, the stored post words appear on `sys_dout` one per cycle from system edge k+2, with `sys_dout_vld` high for each of them, for at most BURST_LEN words.
- R7: A read request that finds the fill queue empty produces no `bus_dout_vld` pulse and sets `bus_fill_udf`.
- R8: A capture cycle that finds the fill queue full is dropped, the words already stored are left unchanged, and `sys_fill_ovf` is set.
- R9: A drain cycle that finds the post queue empty produces no `sys_dout_vld` pulse and sets `sys_drain_udf`.
- R10: A write strobe that finds the post queue full is dropped, the words already stored are left unchanged, and `bus_post_ovf` is set.
- R11: Once set, each error flag stays high until the reset of its own clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| sys_fill_rply | input | 1 | Reply strobe that starts a fill capture burst |
| sys_drain_rply | input | 1 | Reply strobe that starts a post drain burst |
| sys_din | input | DATA_W | Interconnect data bus into the block |
| sys_dout | output | DATA_W | Drained word toward the interconnect |
| sys_dout_vld | output | 1 | High while `sys_dout` carries a drained word |
| sys_fill_ovf | output | 1 | Sticky flag: capture attempted while fill queue full |
| sys_drain_udf | output | 1 | Sticky flag: drain attempted while post queue empty |
| bus_clk | input | 1 | Processor-side bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| bus_rd_req | input | 1 | Per-word read strobe for the fill queue |
| bus_wr_req | input | 1 | Per-word write strobe for the post queue |
| bus_din | input | DATA_W | Processor data written with `bus_wr_req` |
| bus_dout | output | DATA_W | Word returned to the processor |
| bus_dout_vld | output | 1 | One-cycle pulse marking a returned word |
| bus_fill_udf | output | 1 | Sticky flag: read attempted while fill queue empty |
| bus_post_ovf | output | 1 | Sticky flag: write attempted while post queue full |

## Verification
The latency assertions assume that a strobe is judged against the queue state its own domain can see. They also assume that both resets are held together for several cycles of the slower clock. A word is visible to the far side only after the synchroniser delay, so the stimulus lets at least ten bus cycles pass after a burst before the opposite domain touches that queue. The stimulus drives every input on the falling edge of its own clock and samples the outputs there too, so coincident rising edges of the two clocks never decide a result.

// File: rtl/xbuf_pkg.sv
// Shared constants for the dual-clock data buffer.
// Assumes: nothing beyond a synchronous active-low reset in each clock domain.
package xbuf_pkg;
    // Number of flops in each clock-crossing synchroniser chain.
    localparam int XB_SYNC_STAGES = 2;
endpackage

// File: rtl/xbuf_sync.sv
// Multi-flop synchroniser carrying a Gray-coded pointer into another domain.
// Assumes: the input changes by at most one bit per source clock (Gray code).
module xbuf_sync #(
    parameter int W      = 3,
    parameter int STAGES = xbuf_pkg::XB_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the source value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xbuf_burst.sv
// Burst sequencer: one start pulse opens a window of LEN consecutive cycles.
// Assumes: a start that arrives while a window is open is ignored.
module xbuf_burst #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] remain;

    // Load the window length on start, then count it down one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                       remain <= '0;
        else if (remain != '0)            remain <= remain - 1'b1;
        else if (start)                   remain <= CW'(LEN);
    end

    assign active = (remain != '0);

    // A window opens only in the cycle after a start pulse.
    assert_burst_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start));
endmodule

// File: rtl/xbuf_fifo.sv
// Dual-clock queue with Gray-coded pointers and a registered read port.
// Assumes: the write and read resets are applied together.
// A push into a full queue or a pop from an empty one is dropped and
// raises a sticky flag in the domain that made the request.
module xbuf_fifo #(
    parameter int W  = 32,
    parameter int AW = 2
) (
    input  logic         wclk,
    input  logic         wrst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         ovf_err,
    input  logic         rclk,
    input  logic         rrst_n,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         rd_ok,
    output logic         udf_err
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_at_w, wgray_at_r, rbin_at_w, wbin_at_r;
    logic          full, empty, push, pop;

    xbuf_sync #(.W(PW)) u_rptr_sync (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_at_w));
    xbuf_sync #(.W(PW)) u_wptr_sync (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_at_r));

    // Derive full and empty from the synchronised far-side pointers.
    always_comb begin
        rbin_at_w = to_bin(rgray_at_w);
        wbin_at_r = to_bin(wgray_at_r);
        full  = (wbin[AW] != rbin_at_w[AW]) && (wbin[AW-1:0] == rbin_at_w[AW-1:0]);
        empty = (rbin == wbin_at_r);
        push  = wr_en && !full;
        pop   = rd_en && !empty;
    end

    // Write the storage array on an accepted push.
    always_ff @(posedge wclk) begin
        if (push) store[wbin[AW-1:0]] <= wr_data;
    end

    // Advance the write pointer and record rejected pushes.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            ovf_err <= 1'b0;
        end else begin
            if (push) begin
                wbin  <= wbin + 1'b1;
                wgray <= to_gray(wbin + 1'b1);
            end
            if (wr_en && full) ovf_err <= 1'b1;
        end
    end

    // Advance the read pointer, register the popped word, record rejected pops.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            rd_data <= '0;
            rd_ok   <= 1'b0;
            udf_err <= 1'b0;
        end else begin
            rd_ok <= pop;
            if (pop) begin
                rd_data <= store[rbin[AW-1:0]];
                rbin    <= rbin + 1'b1;
                rgray   <= to_gray(rbin + 1'b1);
            end
            if (rd_en && empty) udf_err <= 1'b1;
        end
    end

    // A push that meets a full queue leaves the write pointer alone (also R10).
    assert_no_overflow_R8: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_en && full) |=> $stable(wbin));
    // A pop that meets an empty queue leaves the read pointer alone (also R9).
    assert_no_underflow_R7: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && empty) |=> ($stable(rbin) && !rd_ok));
    assert_sticky_ovf_R11: assert property (@(posedge wclk) disable iff (!wrst_n)
        ovf_err |=> ovf_err);
    assert_sticky_udf_R11: assert property (@(posedge rclk) disable iff (!rrst_n)
        udf_err |=> udf_err);
endmodule

// File: rtl/xclk_data_buffer.sv
// Bidirectional data buffer between a system-clock interconnect and a
// bus-clock processor data bus, the clocks locked at a 2:3 ratio.
// Fill: one system reply captures BURST_LEN words; the processor reads
// them one per strobe, each returned two bus cycles after its strobe.
// Post: the processor writes one word per strobe; one system reply drains
// up to BURST_LEN words, the first two system cycles after the reply.
// Assumes: each reset is held for several cycles of the slower clock.
module xclk_data_buffer #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 2,
    parameter int BURST_LEN = 4
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              sys_fill_rply,
    input  logic              sys_drain_rply,
    input  logic [DATA_W-1:0] sys_din,
    output logic [DATA_W-1:0] sys_dout,
    output logic              sys_dout_vld,
    output logic              sys_fill_ovf,
    output logic              sys_drain_udf,
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_rd_req,
    input  logic              bus_wr_req,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_vld,
    output logic              bus_fill_udf,
    output logic              bus_post_ovf
);
    logic              fill_active, drain_active;
    logic [DATA_W-1:0] fill_rd_data, post_rd_data, bus_mid_data;
    logic              fill_rd_ok, post_rd_ok, bus_mid_vld;

    xbuf_burst #(.LEN(BURST_LEN)) u_fill_burst (
        .clk(sys_clk), .rst_n(sys_rst_n), .start(sys_fill_rply), .active(fill_active));

    xbuf_burst #(.LEN(BURST_LEN)) u_drain_burst (
        .clk(sys_clk), .rst_n(sys_rst_n), .start(sys_drain_rply), .active(drain_active));

    xbuf_fifo #(.W(DATA_W), .AW(ADDR_W)) u_fill_q (
        .wclk(sys_clk), .wrst_n(sys_rst_n), .wr_en(fill_active), .wr_data(sys_din),
        .ovf_err(sys_fill_ovf),
        .rclk(bus_clk), .rrst_n(bus_rst_n), .rd_en(bus_rd_req), .rd_data(fill_rd_data),
        .rd_ok(fill_rd_ok), .udf_err(bus_fill_udf));

    xbuf_fifo #(.W(DATA_W), .AW(ADDR_W)) u_post_q (
        .wclk(bus_clk), .wrst_n(bus_rst_n), .wr_en(bus_wr_req), .wr_data(bus_din),
        .ovf_err(bus_post_ovf),
        .rclk(sys_clk), .rrst_n(sys_rst_n), .rd_en(drain_active), .rd_data(post_rd_data),
        .rd_ok(post_rd_ok), .udf_err(sys_drain_udf));

    // Two-stage return pipeline toward the processor.
    always_ff @(posedge bus_clk) begin
        if (!bus_rst_n) begin
            bus_mid_vld  <= 1'b0;
            bus_mid_data <= '0;
            bus_dout_vld <= 1'b0;
            bus_dout     <= '0;
        end else begin
            bus_mid_vld  <= fill_rd_ok;
            bus_dout_vld <= bus_mid_vld;
            if (fill_rd_ok)  bus_mid_data <= fill_rd_data;
            if (bus_mid_vld) bus_dout     <= bus_mid_data;
        end
    end

    // Output register toward the interconnect.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) begin
            sys_dout_vld <= 1'b0;
            sys_dout     <= '0;
        end else begin
            sys_dout_vld <= post_rd_ok;
            if (post_rd_ok) sys_dout <= post_rd_data;
        end
    end

    // A returned word always traces back to a read strobe three samples earlier.
    assert_rd_latency_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        bus_dout_vld |-> $past(bus_rd_req, 3));
    // A drained word always traces back to an open drain window two samples earlier.
    assert_drain_latency_R6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        sys_dout_vld |-> $past(drain_active, 2));
    // The return pulse on the processor side never lasts two cycles for one strobe.
    assert_rd_pulse_R3: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_dout_vld && !$past(bus_rd_req, 2)) |=> !bus_dout_vld);
endmodule

// File: tb/xclk_data_buffer_bench.sv
// Directed bench: both clocks at a 2:3 ratio (bus clock 200 MHz).
module xclk_data_buffer_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 32;
    localparam int BL = 4;

    logic          sys_clk = 1'b0, bus_clk = 1'b0;
    logic          sys_rst_n = 1'b0, bus_rst_n = 1'b0;
    logic          sys_fill_rply = 1'b0, sys_drain_rply = 1'b0;
    logic [DW-1:0] sys_din = '0, bus_din = '0;
    logic          bus_rd_req = 1'b0, bus_wr_req = 1'b0;
    logic [DW-1:0] sys_dout, bus_dout;
    logic          sys_dout_vld, bus_dout_vld;
    logic          sys_fill_ovf, sys_drain_udf, bus_fill_udf, bus_post_ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5  bus_clk = ~bus_clk;
    always #3.75 sys_clk = ~sys_clk;

    xclk_data_buffer #(.DATA_W(DW), .ADDR_W(2), .BURST_LEN(BL)) u_xclk_data_buffer (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .sys_fill_rply(sys_fill_rply),
        .sys_drain_rply(sys_drain_rply), .sys_din(sys_din), .sys_dout(sys_dout),
        .sys_dout_vld(sys_dout_vld), .sys_fill_ovf(sys_fill_ovf), .sys_drain_udf(sys_drain_udf),
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_rd_req(bus_rd_req),
        .bus_wr_req(bus_wr_req), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_dout_vld(bus_dout_vld), .bus_fill_udf(bus_fill_udf), .bus_post_ovf(bus_post_ovf));

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge bus_clk);
    endtask

    task automatic do_reset();
        @(negedge sys_clk);
        sys_rst_n = 1'b0;
        bus_rst_n = 1'b0;
        repeat (4) @(negedge sys_clk);
        sys_rst_n = 1'b1;
        bus_rst_n = 1'b1;
        settle();
    endtask

    // R1: reset state on every output.
    task automatic t_reset_state();
        check("R1 sys_dout_vld", DW'(sys_dout_vld), '0);
        check("R1 bus_dout_vld", DW'(bus_dout_vld), '0);
        check("R1 sys_dout", sys_dout, '0);
        check("R1 bus_dout", bus_dout, '0);
        check("R1 error flags", DW'({sys_fill_ovf, sys_drain_udf, bus_fill_udf, bus_post_ovf}), '0);
    endtask

    // R2: one reply, then BL words on consecutive system cycles.
    task automatic fill_burst(input logic [DW-1:0] base);
        @(negedge sys_clk);
        sys_fill_rply = 1'b1;
        for (int i = 0; i < BL; i++) begin
            @(negedge sys_clk);
            sys_fill_rply = 1'b0;
            sys_din = base + DW'(i);
        end
        @(negedge sys_clk);
        sys_din = 32'hDEAD_BEEF;
    endtask

    // R3: one read strobe, exact two-cycle return, single-cycle pulse.
    task automatic read_word(input string req, input bit exp_vld, input logic [DW-1:0] exp);
        @(negedge bus_clk);
        bus_rd_req = 1'b1;
        @(negedge bus_clk);
        bus_rd_req = 1'b0;
        check({req, " no early vld k"}, DW'(bus_dout_vld), '0);
        @(negedge bus_clk);
        check({req, " no early vld k+1 R3"}, DW'(bus_dout_vld), '0);
        @(negedge bus_clk);
        check({req, " vld at k+2 R3"}, DW'(bus_dout_vld), DW'(exp_vld));
        if (exp_vld) check({req, " data R4"}, bus_dout, exp);
        @(negedge bus_clk);
        check({req, " pulse ends R3"}, DW'(bus_dout_vld), '0);
    endtask

    // R5: one word per write strobe, data in the strobe cycle.
    task automatic write_words(input logic [DW-1:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge bus_clk);
            bus_wr_req = 1'b1;
            bus_din = base + DW'(i);
        end
        @(negedge bus_clk);
        bus_wr_req = 1'b0;
        bus_din = 32'hBAD0_BAD0;
    endtask

    // R6: one drain reply, words from k+2 on consecutive cycles.
    task automatic drain_burst(input string req, input int nvalid, input logic [DW-1:0] base);
        @(negedge sys_clk);
        sys_drain_rply = 1'b1;
        @(negedge sys_clk);
        sys_drain_rply = 1'b0;
        check({req, " no vld k R6"}, DW'(sys_dout_vld), '0);
        @(negedge sys_clk);
        check({req, " no vld k+1 R6"}, DW'(sys_dout_vld), '0);
        for (int i = 0; i < BL; i++) begin
            @(negedge sys_clk);
            check({req, " vld slot R6"}, DW'(sys_dout_vld), DW'(i < nvalid));
            if (i < nvalid) check({req, " data order R4 R5"}, sys_dout, base + DW'(i));
        end
        @(negedge sys_clk);
        check({req, " burst ends R6"}, DW'(sys_dout_vld), '0);
    endtask

    task automatic t_fill_read();
        fill_burst(32'hA000_0010);
        settle();
        for (int i = 0; i < BL; i++) read_word("R2 fill/read", 1'b1, 32'hA000_0010 + DW'(i));
        check("R7 no udf after valid reads", DW'(bus_fill_udf), '0);
        check("R8 no ovf after one burst", DW'(sys_fill_ovf), '0);
    endtask

    task automatic t_write_drain();
        write_words(32'h5000_0100, BL);
        settle();
        drain_burst("R5 write/drain", BL, 32'h5000_0100);
        check("R9 no udf after full drain", DW'(sys_drain_udf), '0);
        check("R10 no ovf after four writes", DW'(bus_post_ovf), '0);
    endtask

    task automatic t_drain_empty();
        settle();
        drain_burst("R9 empty drain", 0, '0);
        check("R9 drain udf flag", DW'(sys_drain_udf), 32'd1);
    endtask

    task automatic t_fill_overflow();
        fill_burst(32'hC000_0000);
        fill_burst(32'hEEEE_0000);
        settle();
        check("R8 fill ovf flag", DW'(sys_fill_ovf), 32'd1);
        for (int i = 0; i < BL; i++) read_word("R8 stored kept", 1'b1, 32'hC000_0000 + DW'(i));
    endtask

    task automatic t_read_empty();
        settle();
        read_word("R7 empty read", 1'b0, '0);
        check("R7 read udf flag", DW'(bus_fill_udf), 32'd1);
    endtask

    task automatic t_post_overflow();
        write_words(32'h7000_0000, BL + 1);
        settle();
        check("R10 post ovf flag", DW'(bus_post_ovf), 32'd1);
        drain_burst("R10 stored kept", BL, 32'h7000_0000);
    endtask

    task automatic t_sticky();
        fill_burst(32'h1234_0000);
        settle();
        for (int i = 0; i < BL; i++) read_word("R11 traffic", 1'b1, 32'h1234_0000 + DW'(i));
        check("R11 flags stay set", DW'({sys_fill_ovf, sys_drain_udf, bus_fill_udf, bus_post_ovf}), 32'hF);
        do_reset();
        check("R11 flags cleared by reset", DW'({sys_fill_ovf, sys_drain_udf, bus_fill_udf, bus_post_ovf}), '0);
        t_reset_state();
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_fill_read();
        t_write_drain();
        t_drain_empty();
        t_fill_overflow();
        t_read_empty();
        t_post_overflow();
        t_sticky();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge bus_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule